// File: doc/BRIEF.md
# Operand Access Break Comparator

This block watches the operand bus cycles of a processor and asks for a user break when an access matches a configured condition. Each valid bus cycle presents an address, an address-space identifier, an access-size code, up to 64 bits of access data and a flag for accesses that move no data. The comparator checks these against a set of static configuration inputs: a break address with a bit mask, a break identifier, a break data word with a bit mask, a size code, a data-compare enable and a data-access-type field.

The address bits that take part in the compare depend on the size of the break. When data comparison is on, the block picks the byte, word or longword lane that the address offset selects. For a quadword it tests each 32-bit half on its own. An access that carries no data cannot cause a break while data comparison is on. The result is registered and comes out as a one-clock pulse per matching bus cycle.

Top module: `opbrk_cmp`

## Requirements
- R1: `brk` is low out of reset. It goes high in the clock cycle after a matching access is sampled with `acc_valid` high, and it stays high for that one cycle only. An access without `acc_valid` never raises it.
- R2: When `cfg_size` is 3'b000, every access size is accepted. Otherwise `acc_size` must equal `cfg_size`, where 3'b001 = byte, 3'b010 = word, 3'b011 = longword and 3'b100 = quadword.
- R3: The address compare uses bits 31:3 for a quadword break, 31:2 for longword, 31:1 for word, and 31:0 for a byte break or for `cfg_size` 3'b000. A 1 in `cfg_amask` removes that address bit from the compare.
- R4: When `cfg_asid_en` is 1, `acc_asid` must equal `cfg_asid`. When it is 0, the identifier is ignored.
- R5: When `cfg_data_en` is 1, a break needs the address, the identifier and the masked data to match together. A 1 in `cfg_dmask` removes that data bit from the compare. A longword is taken from `acc_data[63:32]` when `acc_addr[2]` is 1 and from `acc_data[31:0]` otherwise.
- R6: For a quadword access with data comparison on, `cfg_data` is compared with `acc_data[63:32]` and with `acc_data[31:0]`, and a match on either half is enough.
- R7: A byte access is compared in the lane `acc_data[8*acc_addr[2:0] +: 8]` against `cfg_data[7:0]`. A word access is compared in the lane `acc_data[16*acc_addr[2:1] +: 16]` against `cfg_data[15:0]`. For both sizes, bits 31:16 of `cfg_data` and `cfg_dmask` have no effect.
- R8: While `cfg_data_en` is 1, an access with `acc_nodata` high never breaks. While `cfg_data_en` is 0, such an access breaks on the other conditions alone.
- R9: With `cfg_data_en` at 1, a break can occur only when `cfg_dtype` is 2'b10 or 2'b11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Operand bus cycle strobe |
| acc_addr | input | 32 | Access address |
| acc_asid | input | ASID_W | Access address-space identifier |
| acc_size | input | 3 | Access size code |
| acc_data | input | 64 | Lane-aligned access data |
| acc_nodata | input | 1 | Access carries no data |
| cfg_addr | input | 32 | Break address |
| cfg_amask | input | 32 | Address mask, 1 = bit ignored |
| cfg_asid | input | ASID_W | Break identifier |
| cfg_asid_en | input | 1 | Enable identifier compare |
| cfg_size | input | 3 | Break size code |
| cfg_data | input | 32 | Break data |
| cfg_dmask | input | 32 | Data mask, 1 = bit ignored |
| cfg_data_en | input | 1 | Enable data compare |
| cfg_dtype | input | 2 | Data-access-type field |
| brk | output | 1 | Break request pulse |

## Verification
All match logic is combinational and feeds one output register, so each result is due exactly one rising edge after the access is presented. The bench drives each access on a falling edge and reads `brk` on the next falling edge, which is half a period after the edge that registers the result. The pulse-width check removes `acc_valid` and samples again one falling edge later, where `brk` must be low once more.

// File: rtl/opbrk_cmp.sv
module opbrk_cmp #(
  parameter int ASID_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic [31:0]       acc_addr,
  input  logic [ASID_W-1:0] acc_asid,
  input  logic [2:0]        acc_size,
  input  logic [63:0]       acc_data,
  input  logic              acc_nodata,
  input  logic [31:0]       cfg_addr,
  input  logic [31:0]       cfg_amask,
  input  logic [ASID_W-1:0] cfg_asid,
  input  logic              cfg_asid_en,
  input  logic [2:0]        cfg_size,
  input  logic [31:0]       cfg_data,
  input  logic [31:0]       cfg_dmask,
  input  logic              cfg_data_en,
  input  logic [1:0]        cfg_dtype,
  output logic              brk
);
  localparam logic [2:0] SZ_ANY  = 3'b000;
  localparam logic [2:0] SZ_BYTE = 3'b001;
  localparam logic [2:0] SZ_WORD = 3'b010;
  localparam logic [2:0] SZ_LONG = 3'b011;
  localparam logic [2:0] SZ_QUAD = 3'b100;

  logic [31:0] low_ign;
  logic [7:0]  b_lane;
  logic [15:0] w_lane;
  logic [31:0] l_lane;
  logic        data_hit;

  always_comb begin
    case (cfg_size)
      SZ_QUAD: low_ign = 32'h7;
      SZ_LONG: low_ign = 32'h3;
      SZ_WORD: low_ign = 32'h1;
      default: low_ign = 32'h0;
    endcase
  end

  wire addr_hit = ((acc_addr ^ cfg_addr) & ~(cfg_amask | low_ign)) == 32'h0;
  wire size_hit = (cfg_size == SZ_ANY) || (acc_size == cfg_size);
  wire asid_hit = !cfg_asid_en || (acc_asid == cfg_asid);

  assign b_lane = acc_data[{acc_addr[2:0], 3'b000} +: 8];
  assign w_lane = acc_data[{acc_addr[2:1], 4'b0000} +: 16];
  assign l_lane = acc_data[{acc_addr[2], 5'b00000} +: 32];

  wire hi_hit = ((acc_data[63:32] ^ cfg_data) & ~cfg_dmask) == 32'h0;
  wire lo_hit = ((acc_data[31:0]  ^ cfg_data) & ~cfg_dmask) == 32'h0;

  always_comb begin
    case (acc_size)
      SZ_BYTE: data_hit = ((b_lane ^ cfg_data[7:0])  & ~cfg_dmask[7:0])  == 8'h0;
      SZ_WORD: data_hit = ((w_lane ^ cfg_data[15:0]) & ~cfg_dmask[15:0]) == 16'h0;
      SZ_LONG: data_hit = ((l_lane ^ cfg_data)       & ~cfg_dmask)       == 32'h0;
      SZ_QUAD: data_hit = hi_hit || lo_hit;
      default: data_hit = 1'b0;
    endcase
  end

  wire data_ok = !cfg_data_en || (cfg_dtype[1] && !acc_nodata && data_hit);
  wire hit     = acc_valid && addr_hit && size_hit && asid_hit && data_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) brk <= 1'b0;
    else        brk <= hit;
  end
endmodule

// File: rtl/opbrk_cmp_chk.sv
module opbrk_cmp_chk #(
  parameter int ASID_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              acc_valid,
  input logic [31:0]       acc_addr,
  input logic [ASID_W-1:0] acc_asid,
  input logic [2:0]        acc_size,
  input logic [63:0]       acc_data,
  input logic              acc_nodata,
  input logic [31:0]       cfg_addr,
  input logic [31:0]       cfg_amask,
  input logic [ASID_W-1:0] cfg_asid,
  input logic              cfg_asid_en,
  input logic [2:0]        cfg_size,
  input logic [31:0]       cfg_data,
  input logic [31:0]       cfg_dmask,
  input logic              cfg_data_en,
  input logic [1:0]        cfg_dtype,
  input logic              brk
);
  // R1
  no_strobe_no_brk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |=> !brk);
  // R2
  size_mismatch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && cfg_size != 3'b000 && acc_size != cfg_size) |=> !brk);
  // R3
  high_addr_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && (((acc_addr ^ cfg_addr) & ~cfg_amask & 32'hFFFF_FFF8) != 32'h0)) |=> !brk);
  // R4
  asid_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && cfg_asid_en && acc_asid != cfg_asid) |=> !brk);
  // R8
  nodata_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && cfg_data_en && acc_nodata) |=> !brk);
  // R9
  dtype_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && cfg_data_en && !cfg_dtype[1]) |=> !brk);
endmodule

bind opbrk_cmp opbrk_cmp_chk #(.ASID_W(ASID_W)) chk (.*);

// File: tb/tb_opbrk_cmp.sv
`timescale 1ns/1ps
module tb_opbrk_cmp;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 1'b0;
  logic [31:0] acc_addr = '0;
  logic [7:0]  acc_asid = '0;
  logic [2:0]  acc_size = '0;
  logic [63:0] acc_data = '0;
  logic        acc_nodata = 1'b0;
  logic [31:0] cfg_addr = 32'h8000_1234;
  logic [31:0] cfg_amask = '0;
  logic [7:0]  cfg_asid = 8'd5;
  logic        cfg_asid_en = 1'b1;
  logic [2:0]  cfg_size = 3'b011;
  logic [31:0] cfg_data = '0;
  logic [31:0] cfg_dmask = '0;
  logic        cfg_data_en = 1'b0;
  logic [1:0]  cfg_dtype = 2'b10;
  logic        brk;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  opbrk_cmp dut (.*);

  task automatic check(input logic exp, input string tag);
    checks++;
    if (brk !== exp) begin
      fails++;
      $display("FAIL %s: brk=%b expected %b", tag, brk, exp);
    end
  endtask

  task automatic access(input logic [31:0] a, input logic [2:0] sz, input logic [63:0] d,
                        input logic nd, input logic [7:0] id, input logic exp, input string tag);
    @(negedge clk);
    acc_valid = 1'b1; acc_addr = a; acc_size = sz; acc_data = d; acc_nodata = nd; acc_asid = id;
    @(negedge clk);
    acc_valid = 1'b0;
    check(exp, tag);
  endtask

  task automatic t_reset();
    check(1'b0, "R1 reset");
  endtask

  task automatic t_pulse();
    cfg_size = 3'b011; cfg_addr = 32'h8000_1234; cfg_amask = '0; cfg_data_en = 1'b0;
    access(32'h8000_1234, 3'b011, '0, 1'b0, 8'd5, 1'b1, "R1 hit");
    @(negedge clk);
    check(1'b0, "R1 one-cycle pulse");
  endtask

  task automatic t_addr_size();
    cfg_size = 3'b011; cfg_addr = 32'h8000_1234;
    access(32'h8000_1237, 3'b011, '0, 1'b0, 8'd5, 1'b1, "R3 long ignores 1:0");
    access(32'h8000_1238, 3'b011, '0, 1'b0, 8'd5, 1'b0, "R3 long bit2 differs");
    access(32'h8000_1234, 3'b010, '0, 1'b0, 8'd5, 1'b0, "R2 size mismatch");
    cfg_size = 3'b100; cfg_addr = 32'h8000_1230;
    access(32'h8000_1237, 3'b100, '0, 1'b0, 8'd5, 1'b1, "R3 quad ignores 2:0");
    cfg_size = 3'b001; cfg_addr = 32'h8000_1234;
    access(32'h8000_1235, 3'b001, '0, 1'b0, 8'd5, 1'b0, "R3 byte full compare");
    cfg_size = 3'b000;
    access(32'h8000_1234, 3'b001, '0, 1'b0, 8'd5, 1'b1, "R2 any size byte");
    access(32'h8000_1234, 3'b100, '0, 1'b0, 8'd5, 1'b1, "R2 any size quad");
    access(32'h8000_1235, 3'b001, '0, 1'b0, 8'd5, 1'b0, "R3 size any full compare");
    cfg_amask = 32'h0000_00F0;
    access(32'h8000_12C4, 3'b011, '0, 1'b0, 8'd5, 1'b1, "R3 masked bits");
    cfg_amask = '0;
  endtask

  task automatic t_asid();
    cfg_size = 3'b011; cfg_addr = 32'h8000_1234;
    access(32'h8000_1234, 3'b011, '0, 1'b0, 8'd6, 1'b0, "R4 asid miss");
    cfg_asid_en = 1'b0;
    access(32'h8000_1234, 3'b011, '0, 1'b0, 8'd6, 1'b1, "R4 asid bypass");
    cfg_asid_en = 1'b1;
  endtask

  task automatic t_data();
    cfg_data_en = 1'b1; cfg_dtype = 2'b10; cfg_size = 3'b011; cfg_addr = 32'h8000_1234;
    cfg_data = 32'hDEAD_BEEF; cfg_dmask = '0;
    access(32'h8000_1234, 3'b011, 64'hDEAD_BEEF_0000_0000, 1'b0, 8'd5, 1'b1, "R5 long upper lane");
    access(32'h8000_1234, 3'b011, 64'h0000_0000_DEAD_BEEF, 1'b0, 8'd5, 1'b0, "R5 long wrong lane");
    cfg_dmask = 32'h0000_FFFF;
    access(32'h8000_1234, 3'b011, 64'hDEAD_0000_0000_0000, 1'b0, 8'd5, 1'b1, "R5 data mask");
    cfg_dmask = '0;
    cfg_size = 3'b100; cfg_addr = 32'h8000_1230; cfg_data = 32'h1234_5678;
    access(32'h8000_1230, 3'b100, 64'hFFFF_FFFF_1234_5678, 1'b0, 8'd5, 1'b1, "R6 quad low half");
    access(32'h8000_1230, 3'b100, 64'h1234_5678_0000_0000, 1'b0, 8'd5, 1'b1, "R6 quad high half");
    access(32'h8000_1230, 3'b100, 64'h1234_5679_1234_5670, 1'b0, 8'd5, 1'b0, "R6 quad neither");
    cfg_size = 3'b001; cfg_addr = 32'h8000_1235; cfg_data = 32'hFFFF_A5A5; cfg_dmask = 32'h5A5A_0000;
    access(32'h8000_1235, 3'b001, 64'h0000_A500_0000_0000, 1'b0, 8'd5, 1'b1, "R7 byte lane 5");
    access(32'h8000_1235, 3'b001, 64'h0000_00A5_0000_0000, 1'b0, 8'd5, 1'b0, "R7 byte wrong lane");
    cfg_size = 3'b010; cfg_addr = 32'h8000_1232; cfg_data = 32'h9999_C3C3;
    access(32'h8000_1232, 3'b010, 64'h0000_0000_C3C3_0000, 1'b0, 8'd5, 1'b1, "R7 word lane 1");
    access(32'h8000_1232, 3'b010, 64'h0000_0000_0000_C3C3, 1'b0, 8'd5, 1'b0, "R7 word wrong lane");
    cfg_dmask = '0;
  endtask

  task automatic t_nodata_dtype();
    cfg_size = 3'b011; cfg_addr = 32'h8000_1234; cfg_data = 32'hCAFE_F00D;
    cfg_data_en = 1'b1; cfg_dtype = 2'b10;
    access(32'h8000_1234, 3'b011, 64'hCAFE_F00D_0000_0000, 1'b1, 8'd5, 1'b0, "R8 nodata suppressed");
    cfg_data_en = 1'b0;
    access(32'h8000_1234, 3'b011, '0, 1'b1, 8'd5, 1'b1, "R8 nodata without data compare");
    cfg_data_en = 1'b1; cfg_dtype = 2'b01;
    access(32'h8000_1234, 3'b011, 64'hCAFE_F00D_0000_0000, 1'b0, 8'd5, 1'b0, "R9 dtype 01 blocks");
    cfg_dtype = 2'b11;
    access(32'h8000_1234, 3'b011, 64'hCAFE_F00D_0000_0000, 1'b0, 8'd5, 1'b1, "R9 dtype 11 allows");
    cfg_data_en = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_pulse();
    t_addr_size();
    t_asid();
    t_data();
    t_nodata_dtype();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: finished=0 expected 1");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule